// File: doc/BRIEF.md
# Banked Interrupt Enable and Priority Selector

This block gates a wide set of level-sensitive pending inputs with per-line enable bits, holds a priority byte for each line, and presents the single best ready line to a consumer. Lines are grouped into banks of 32. With the full sixteen-bank build the top bank has only sixteen lines, which gives 496 lines. Enable bits are never written directly. A word written to the set window turns on the lines whose bits are one, and a word written to the clear window turns off the lines whose bits are one. Software can therefore change one line without reading the bank first, and it cannot race another writer of the same bank.

A consumer watches `irqValid`, `irqLine` and `irqPrio`. It pulses `irqTake` to accept the offered line, and that puts the block in service. While in service no further line is offered. A pulse on `irqDone`, outside the register bus, ends service. No completion write is needed on the bus. A read-only word reports how many banks the build has, minus one.

Top module: `banked_irq_enable`

## Requirements
- R1: With NUM_BANKS banks, lines number 0 to NUM_BANKS*32-1, except that a 16-bank build has 496 lines (the top bank holds 16). A read of byte address 0x200 returns NUM_BANKS-1 in bits 3:0 and zero in all other bits.
- R2: A write to 0x000+4*b sets the enable of line 32*b+i for every bit i that is one. Bits written as zero leave their enables unchanged.
- R3: A write to 0x080+4*b clears the enable of line 32*b+i for every bit i that is one. Bits written as zero leave their enables unchanged, so an all-ones word disables the whole bank.
- R4: A read of either 0x000+4*b or 0x080+4*b returns bank b's enable bits, with bit i holding line 32*b+i.
- R5: Bits for lines that do not exist read as zero and ignore writes. This covers bits 31:16 of bank 15 and every bank at or above NUM_BANKS.
- R6: The word at 0x300+4*w holds the priorities of lines 4w to 4w+3, with line 4w+k in bits 8k+7:8k. The word reads back what was written. Bytes for lines that do not exist read as zero, and word addresses past the last line are unmapped.
- R7: After reset, all enables are 0, all priorities are 0, the block is not in service, and busRdata is 0.
- R8: When the block is not in service and some line is both enabled and pending, irqValid is 1 in the same cycle. irqLine is the line with the smallest priority value, ties go to the lower line number, and irqPrio is that line's priority. Pending lines that are not enabled are ignored.
- R9: irqTake while irqValid is 1 sets inService from the next cycle on, and irqValid stays 0 while inService is 1. irqTake while irqValid is 0 has no effect.
- R10: irqDone while in service clears inService on the next cycle. irqDone while not in service has no effect.
- R11: busRdata changes only on the cycle after a read (busSel=1, busWrite=0) and then shows the addressed word. Unmapped addresses read as 0 and ignore writes. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 11 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| pendIn | input | NUM_LINES | Level pending inputs, one per line |
| irqTake | input | 1 | Accept the offered line |
| irqDone | input | 1 | Service complete |
| irqValid | output | 1 | A line is offered |
| irqLine | output | 9 | Offered line number |
| irqPrio | output | 8 | Offered line's priority |
| inService | output | 1 | A taken line has not yet been completed |

## Verification
Several properties are checked on every cycle:
- An offered line is always pending and in range.
- Nothing is offered while in service.
- Service starts only from an accepted offer and ends only after a done pulse.
- Read data holds between reads.

Other behaviours can only be shown by the bench's scenarios compared against its reference model. These are:
- which line wins on priority and on line number;
- that the set and clear windows leave zero bits alone;
- the clipped top bank and the unmapped words;
- the bank-count word.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;

  localparam int BANK_LINES = 32;
  localparam int MAX_BANKS  = 16;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_EN    = 2'd1,
    RD_PRIO  = 2'd2,
    RD_COUNT = 2'd3
  } rdSrc_e;

  // Strobes from the address decoder to the storage datapath
  typedef struct packed {
    logic       setEn;
    logic       clrEn;
    logic       prioWr;
    logic       rdEn;
    rdSrc_e     rdSrc;
    logic [3:0] bankIdx;
    logic [6:0] wordIdx;
  } busStrobe_t;

  // The full build drops the upper half of its top bank
  function automatic int lineCount(input int banks);
    return (banks == MAX_BANKS) ? (banks * BANK_LINES - 16) : (banks * BANK_LINES);
  endfunction

endpackage

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import banked_irq_pkg::*;
#(
  parameter int NUM_BANKS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [10:0] busAddr,
  input  logic        irqTake,
  input  logic        irqDone,
  input  logic        candValid,
  output busStrobe_t  strobe,
  output logic        inService
);
  localparam int NUM_LINES  = lineCount(NUM_BANKS);
  localparam int PRIO_WORDS = (NUM_LINES + 3) / 4;
  localparam int PRIO_BASE  = 'h300 / 4;

  logic [8:0] wordAddr;
  logic [1:0] unusedAddr;
  logic inSet, inClr, inCount, inPrio;
  logic svcQ;

  assign wordAddr   = busAddr[10:2];
  assign unusedAddr = busAddr[1:0];

  assign inSet   = (wordAddr[8:4] == 5'h00);
  assign inClr   = (wordAddr[8:4] == 5'h02);
  assign inCount = (wordAddr == 9'h080);
  assign inPrio  = (int'(wordAddr) >= PRIO_BASE) && (int'(wordAddr) < PRIO_BASE + PRIO_WORDS);

  always_comb begin
    strobe.setEn   = busSel && busWrite && inSet;
    strobe.clrEn   = busSel && busWrite && inClr;
    strobe.prioWr  = busSel && busWrite && inPrio;
    strobe.rdEn    = busSel && !busWrite;
    strobe.bankIdx = wordAddr[3:0];
    strobe.wordIdx = 7'(wordAddr - 9'(PRIO_BASE));
    if (inSet || inClr)  strobe.rdSrc = RD_EN;
    else if (inPrio)     strobe.rdSrc = RD_PRIO;
    else if (inCount)    strobe.rdSrc = RD_COUNT;
    else                 strobe.rdSrc = RD_NONE;
  end

  // One line in service at a time; done takes precedence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               svcQ <= 1'b0;
    else if (svcQ && irqDone)                svcQ <= 1'b0;
    else if (!svcQ && irqTake && candValid)  svcQ <= 1'b1;
  end

  assign inService = svcQ;

endmodule

// File: rtl/banked_irq_datapath.sv
module banked_irq_datapath
  import banked_irq_pkg::*;
#(
  parameter int NUM_BANKS = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  busStrobe_t                    strobe,
  input  logic [31:0]                   busWdata,
  input  logic [lineCount(NUM_BANKS)-1:0] pendIn,
  output logic [31:0]                   busRdata,
  output logic                          candValid,
  output logic [8:0]                    candLine,
  output logic [7:0]                    candPrio
);
  localparam int NUM_LINES = lineCount(NUM_BANKS);

  logic [NUM_LINES-1:0] enBits;
  logic [7:0]           prioArr [NUM_LINES];
  logic [31:0]          rdNext;
  logic [31:0]          rdQ;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam logic [3:0] BANK = 4'(g / 32);
    localparam int         BITP = g % 32;
    localparam logic [6:0] WORD = 7'(g / 4);
    localparam int         LANE = g % 4;
    logic       enQ;
    logic [7:0] prQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) enQ <= 1'b0;
      else if (strobe.setEn && strobe.bankIdx == BANK && busWdata[BITP]) enQ <= 1'b1;
      else if (strobe.clrEn && strobe.bankIdx == BANK && busWdata[BITP]) enQ <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prQ <= 8'h00;
      else if (strobe.prioWr && strobe.wordIdx == WORD) prQ <= busWdata[8*LANE +: 8];
    end

    assign enBits[g]  = enQ;
    assign prioArr[g] = prQ;
  end

  // Read multiplexer
  always_comb begin
    int ln;
    rdNext = 32'h0;
    ln = 0;
    case (strobe.rdSrc)
      RD_EN: begin
        for (int i = 0; i < NUM_LINES; i++)
          if ((i / 32) == int'(strobe.bankIdx)) rdNext[i % 32] = enBits[i];
      end
      RD_PRIO: begin
        for (int k = 0; k < 4; k++) begin
          ln = int'(strobe.wordIdx) * 4 + k;
          if (ln < NUM_LINES) rdNext[8*k +: 8] = prioArr[ln];
        end
      end
      RD_COUNT: rdNext = 32'(NUM_BANKS - 1);
      default:  rdNext = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdQ <= 32'h0;
    else if (strobe.rdEn) rdQ <= rdNext;
  end

  assign busRdata = rdQ;

  // Lowest priority value wins; strict compare keeps the lower line on ties
  always_comb begin
    candValid = 1'b0;
    candLine  = 9'h0;
    candPrio  = 8'h0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (enBits[i] && pendIn[i] && (!candValid || prioArr[i] < candPrio)) begin
        candValid = 1'b1;
        candLine  = 9'(i);
        candPrio  = prioArr[i];
      end
    end
  end

endmodule

// File: rtl/banked_irq_enable.sv
module banked_irq_enable
  import banked_irq_pkg::*;
#(
  parameter int NUM_BANKS = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busSel,
  input  logic                            busWrite,
  input  logic [10:0]                     busAddr,
  input  logic [31:0]                     busWdata,
  output logic [31:0]                     busRdata,
  input  logic [lineCount(NUM_BANKS)-1:0] pendIn,
  input  logic                            irqTake,
  input  logic                            irqDone,
  output logic                            irqValid,
  output logic [8:0]                      irqLine,
  output logic [7:0]                      irqPrio,
  output logic                            inService
);
  busStrobe_t strobe;
  logic       candValid;
  logic [8:0] candLine;
  logic [7:0] candPrio;

  banked_irq_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .irqTake(irqTake), .irqDone(irqDone), .candValid(candValid),
    .strobe(strobe), .inService(inService)
  );

  banked_irq_datapath #(.NUM_BANKS(NUM_BANKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata), .pendIn(pendIn),
    .busRdata(busRdata), .candValid(candValid), .candLine(candLine), .candPrio(candPrio)
  );

  assign irqValid = candValid && !inService;
  assign irqLine  = candLine;
  assign irqPrio  = candPrio;

endmodule

// File: rtl/banked_irq_enable_chk.sv
module banked_irq_enable_chk
  import banked_irq_pkg::*;
#(
  parameter int NUM_BANKS = 16
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            busSel,
  input logic                            busWrite,
  input logic [31:0]                     busRdata,
  input logic [lineCount(NUM_BANKS)-1:0] pendIn,
  input logic                            irqTake,
  input logic                            irqDone,
  input logic                            irqValid,
  input logic [8:0]                      irqLine,
  input logic                            inService
);
  localparam int NUM_LINES = lineCount(NUM_BANKS);

  p_line_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (int'(irqLine) < NUM_LINES));

  p_line_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> pendIn[irqLine]);

  p_quiet_in_service_r9: assert property (@(posedge clk) disable iff (!rstN)
    inService |-> !irqValid);

  p_enter_from_take_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inService) |-> $past(irqTake && irqValid));

  p_leave_from_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inService) |-> $past(irqDone));

  p_done_ends_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inService && irqDone) |=> !inService);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel || busWrite) |=> $stable(busRdata));

endmodule

bind banked_irq_enable banked_irq_enable_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busRdata(busRdata),
  .pendIn(pendIn), .irqTake(irqTake), .irqDone(irqDone), .irqValid(irqValid),
  .irqLine(irqLine), .inService(inService)
);

// File: tb/banked_irq_enable_test.sv
module banked_irq_enable_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;
  localparam int NL = 496;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0, busWrite = 1'b0;
  logic [10:0]   busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NL-1:0] pendIn = '0;
  logic          irqTake = 1'b0, irqDone = 1'b0;
  logic          irqValid, inService;
  logic [8:0]    irqLine;
  logic [7:0]    irqPrio;

  int    checks = 0, fails = 0;
  string curReq = "R7";
  bit    finished = 0;

  // Reference model state
  bit       mEn [NL];
  bit [7:0] mPrio [NL];
  bit       mSvc;
  bit [31:0] mRd;

  banked_irq_enable #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pendIn(pendIn), .irqTake(irqTake),
    .irqDone(irqDone), .irqValid(irqValid), .irqLine(irqLine), .irqPrio(irqPrio),
    .inService(inService)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void modelPick(output bit v, output int ln, output int pr);
    v = 0; ln = 0; pr = 0;
    for (int i = 0; i < NL; i++)
      if (mEn[i] && pendIn[i] && (!v || int'(mPrio[i]) < pr)) begin
        v = 1; ln = i; pr = int'(mPrio[i]);
      end
  endfunction

  function automatic bit [31:0] modelRead(input int w);
    bit [31:0] r = 0;
    if (w < 16 || (w >= 32 && w < 48)) begin
      for (int b = 0; b < 32; b++)
        if ((w % 16) * 32 + b < NL) r[b] = mEn[(w % 16) * 32 + b];
    end else if (w == 128) begin
      r = 32'(NB - 1);
    end else if (w >= 192) begin
      for (int k = 0; k < 4; k++)
        if ((w - 192) * 4 + k < NL) r[8*k +: 8] = mPrio[(w - 192) * 4 + k];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NL; i++) begin mEn[i] = 0; mPrio[i] = 0; end
      mSvc = 0; mRd = 0;
    end else begin
      bit v; int ln, pr; int w;
      modelPick(v, ln, pr);
      w = int'(busAddr) / 4;
      if (mSvc && irqDone) mSvc = 0;
      else if (!mSvc && irqTake && v) mSvc = 1;
      if (busSel && !busWrite) mRd = modelRead(w);
      if (busSel && busWrite) begin
        if (w < 16) begin
          for (int b = 0; b < 32; b++) if (w*32+b < NL && busWdata[b]) mEn[w*32+b] = 1;
        end else if (w >= 32 && w < 48) begin
          for (int b = 0; b < 32; b++) if ((w-32)*32+b < NL && busWdata[b]) mEn[(w-32)*32+b] = 0;
        end else if (w >= 192) begin
          for (int k = 0; k < 4; k++) if ((w-192)*4+k < NL) mPrio[(w-192)*4+k] = busWdata[8*k +: 8];
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    bit v; int ln, pr;
    @(posedge clk);
    #(CLK_PERIOD/4);
    modelPick(v, ln, pr);
    chk(32'(inService), 32'(mSvc), curReq, "inService");
    chk(32'(irqValid), 32'(v && !mSvc), curReq, "irqValid");
    if (v && !mSvc) begin
      chk(32'(irqLine), 32'(ln), curReq, "irqLine");
      chk(32'(irqPrio), 32'(pr), curReq, "irqPrio");
    end
    chk(busRdata, mRd, curReq, "busRdata");
  endtask

  task automatic busWr(input int a, input logic [31:0] d);
    busSel = 1; busWrite = 1; busAddr = 11'(a); busWdata = d;
    cyc();
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(input int a);
    busSel = 1; busWrite = 0; busAddr = 11'(a);
    cyc();
    busSel = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    rstN = 1;
    // R7: reset state
    curReq = "R7";
    cyc();
    chk(32'(irqValid), 0, "R7", "irqValid after reset");
    busRd('h000); chk(busRdata, 0, "R7", "bank0 enables");
    busRd('h300); chk(busRdata, 0, "R7", "prio word 0");

    // R1: bank count word
    curReq = "R1";
    busRd('h200); chk(busRdata, 32'h0000000F, "R1", "bank count");
    busRd('h203); chk(busRdata, 32'h0000000F, "R11", "low address bits ignored");

    // R2 / R4: set window, zero bits no effect, readback through both windows
    curReq = "R2";
    busWr('h000, 32'h000000F0);
    busWr('h000, 32'h00000000);
    curReq = "R4";
    busRd('h080); chk(busRdata, 32'h000000F0, "R4", "bank0 via clear window");
    busRd('h000); chk(busRdata, 32'h000000F0, "R4", "bank0 via set window");

    // R3: clear window
    curReq = "R3";
    busWr('h080, 32'h00000030);
    busRd('h000); chk(busRdata, 32'h000000C0, "R3", "after partial clear");
    busWr('h084, 32'hFFFFFFFF);
    busWr('h004, 32'hA5A5A5A5);
    busWr('h084, 32'hFFFFFFFF);
    busRd('h004); chk(busRdata, 32'h0, "R3", "all-ones clear");

    // R5: half bank and unimplemented bits
    curReq = "R5";
    busWr('h03C, 32'hFFFFFFFF);
    busRd('h0BC); chk(busRdata, 32'h0000FFFF, "R5", "top bank upper half");
    busWr('h0BC, 32'hFFFFFFFF);

    // R11: unmapped address
    curReq = "R11";
    busWr('h100, 32'hDEADBEEF);
    busRd('h100); chk(busRdata, 32'h0, "R11", "unmapped read");

    // R6: priority array
    curReq = "R6";
    busWr('h300, 32'h05000000);
    busWr('h304, 32'h02000000);
    busWr('h328, 32'h00000002);
    busWr('h4EC, 32'h02000000);
    busRd('h328); chk(busRdata, 32'h00000002, "R6", "prio word 10");
    busRd('h4EC); chk(busRdata, 32'h02000000, "R6", "prio word of last lines");
    busWr('h4F0, 32'h12345678);
    busRd('h4F0); chk(busRdata, 32'h0, "R6", "word past last line");

    // R8: selection
    curReq = "R8";
    busWr('h000, 32'h00000088);
    busWr('h004, 32'h00000100);
    busWr('h03C, 32'h00008000);
    pendIn = '0; pendIn[3] = 1; pendIn[40] = 1; pendIn[0] = 1;
    cyc(); chk(32'(irqLine), 40, "R8", "lower value wins");
    pendIn = '0; pendIn[7] = 1; pendIn[40] = 1; pendIn[495] = 1;
    cyc(); chk(32'(irqLine), 7, "R8", "tie to lower line");
    pendIn = '0; pendIn[3] = 1; pendIn[495] = 1;
    cyc(); chk(32'(irqLine), 495, "R8", "top line by priority");
    pendIn = '0; pendIn[0] = 1;
    cyc(); chk(32'(irqValid), 0, "R8", "disabled pending ignored");

    // R9 / R10: service handshake
    curReq = "R9";
    irqTake = 1; cyc(); irqTake = 0;
    chk(32'(inService), 0, "R9", "take without offer");
    pendIn = '0; pendIn[7] = 1; pendIn[40] = 1;
    irqTake = 1; cyc(); irqTake = 0;
    chk(32'(inService), 1, "R9", "take enters service");
    chk(32'(irqValid), 0, "R9", "no offer in service");
    cyc();
    curReq = "R10";
    irqDone = 1; cyc(); irqDone = 0;
    chk(32'(inService), 0, "R10", "done ends service");
    chk(32'(irqLine), 7, "R10", "offer resumes");
    pendIn = '0;
    irqDone = 1; cyc(); irqDone = 0;
    chk(32'(inService), 0, "R10", "done while idle");

    // Mixed traffic against the model
    curReq = "R8";
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 9);
      int a;
      case (op)
        0: busWr(4 * $urandom_range(0, 15), $urandom);
        1: busWr('h080 + 4 * $urandom_range(0, 15), $urandom & $urandom);
        2: busWr('h300 + 4 * $urandom_range(0, 124), $urandom & 32'h07070707);
        3: begin
             a = $urandom_range(0, 3);
             busRd(a == 0 ? 4 * $urandom_range(0, 15) :
                   a == 1 ? 'h080 + 4 * $urandom_range(0, 15) :
                   a == 2 ? 'h300 + 4 * $urandom_range(0, 124) : 'h200);
           end
        4, 5: begin
             for (int i = 0; i < NL; i++) pendIn[i] = ($urandom_range(0, 15) == 0);
             cyc();
           end
        6, 7: begin irqTake = 1; cyc(); irqTake = 0; end
        default: begin irqDone = 1; cyc(); irqDone = 0; end
      endcase
    end

    summary();
  end

endmodule